// File: doc/BRIEF.md
# Command-Response Buffer Control Register Block

This block holds the control and status registers that a host uses to hand a command to a security-module engine through a shared command/response buffer. The host writes and reads 32-bit registers through a simple memory-mapped port. A write is a command rather than a plain store: requesting a locality updates several status flags at once, a control request moves the engine between idle and ready, and a start write raises a request toward the backend engine. The backend later answers with a completion pulse.

The block passes the backend a command length. This length is the smaller of two values: the size field the host placed in the command header, and the usable buffer size. The usable buffer size is the smaller of the backend's buffer and the data buffer. The block also publishes where that buffer lives and how large it is, together with a fixed interface identification word.

Top module: `cmdrsp_regs`

## Requirements
- R1: A write of exactly 1 to the control-request register (offset 0x40) clears the idle flag, which is bit 1 of control status (offset 0x44). A write of exactly 2 sets that flag. Any other value leaves it unchanged. Idle resets to 0.
- R2: A write of exactly 1 to the start register (offset 0x4C) while its bit 0 reads 0 sets bit 0 and issues one backend request. Such a write while bit 0 reads 1 changes nothing and issues no request.
- R3: The backend request `be_req_valid` is high for exactly one cycle, the cycle right after the accepted start write.
- R4: A write of exactly 1 to the cancel register (offset 0x48) produces a one-cycle `be_cancel` pulse in the next cycle only while start bit 0 is set. Otherwise the write has no effect.
- R5: A `be_done` pulse clears start bit 0. If `be_err` is high with it, the fatal flag (bit 0 of control status) is set, and it stays set until reset.
- R6: A write of exactly 1 to locality control (offset 0x08) sets granted (bit 0) and clears seized (bit 1) in locality status (offset 0x0C). It also sets register-valid (bit 0) and assigned (bit 1) in locality state (offset 0x00).
- R7: Locality control writes of 2 (relinquish), 8 (reset establishment) or any other value besides 1 change nothing.
- R8: The interface identification word at offset 0x30 reads 0x00025811. Its fields are: type [3:0]=1, version [7:4]=1, locality capability bit 8=0, idle bypass bit 9=0, transfer size [12:11]=3, FIFO bit 13=0, buffer interface bit 14=1, selector [18:17]=1, revision [31:24]=0. Offset 0x34 holds the vendor id in [15:0].
- R9: `be_req_len` equals min(`hdr_cmd_size`, BE_BUF_SIZE, DBUF_SIZE) and is sampled with the start write.
- R10: The command size (0x58) and response size (0x64) both read DBUF_SIZE. The command address (0x5C) and response address (0x68) both read DBUF_BASE.
- R11: A read returns the aligned word at `bus_addr` with bits [1:0] masked, shifted right by 8 times `bus_addr[1:0]` and zero-filled.
- R12: Writes to read-only registers do not change what they read. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Host write strobe |
| bus_addr | input | ADDR_W | Host byte address |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Read data, shifted by byte offset |
| hdr_cmd_size | input | 32 | Size field of the command header in the buffer |
| be_req_valid | output | 1 | One-cycle backend request |
| be_req_len | output | LEN_W | Command length for the backend |
| be_cancel | output | 1 | One-cycle cancel toward the backend |
| be_done | input | 1 | Backend completion pulse |
| be_err | input | 1 | Completion carries an error |

## Verification
The bench goes after a start rewritten while busy. A design that re-triggered would emit a second request and send a stale length. It also targets cancel writes made while idle, which a careless decode would forward. Completions are run both with and without error, to show that the fatal flag sets only on error and then holds. Codes that are near misses are written to every command register: 3 to control request, 4 and 8 to locality control, and 2 to start. Headers both above and below the buffer limit check the clamp. Byte-offset reads of the identification word catch a wrong shift direction or a sign fill.

// File: rtl/cr_pkg.sv
package cr_pkg;
   // register offsets (byte addresses, word aligned)
   localparam int unsigned OFS_LOC_STATE  = 'h00;
   localparam int unsigned OFS_LOC_CTRL   = 'h08;
   localparam int unsigned OFS_LOC_STS    = 'h0C;
   localparam int unsigned OFS_INTF_ID    = 'h30;
   localparam int unsigned OFS_INTF_ID2   = 'h34;
   localparam int unsigned OFS_CTRL_REQ   = 'h40;
   localparam int unsigned OFS_CTRL_STS   = 'h44;
   localparam int unsigned OFS_CTRL_CANCEL= 'h48;
   localparam int unsigned OFS_CTRL_START = 'h4C;
   localparam int unsigned OFS_CMD_SIZE   = 'h58;
   localparam int unsigned OFS_CMD_ADDR   = 'h5C;
   localparam int unsigned OFS_RSP_SIZE   = 'h64;
   localparam int unsigned OFS_RSP_ADDR   = 'h68;

   // command codes
   localparam logic [31:0] CODE_READY    = 32'd1;
   localparam logic [31:0] CODE_IDLE     = 32'd2;
   localparam logic [31:0] CODE_GO       = 32'd1;
   localparam logic [31:0] CODE_LOC_REQ  = 32'd1;

   typedef struct packed {
      logic granted;
      logic seized;
      logic assigned;
      logic reg_valid;
   } loc_t;

   typedef struct packed {
      logic idle;
      logic fatal;
   } ctl_t;

   // interface identification fields
   function automatic logic [31:0] intf_id_word();
      logic [31:0] w;
      w        = '0;
      w[3:0]   = 4'd1;  // interface type: buffer active
      w[7:4]   = 4'd1;  // interface version
      w[8]     = 1'b0;  // only locality 0
      w[9]     = 1'b0;  // no idle bypass
      w[12:11] = 2'b11; // 64-byte transfers
      w[13]    = 1'b0;  // no FIFO
      w[14]    = 1'b1;  // buffer interface supported
      w[18:17] = 2'd1;  // buffer interface selected
      w[31:24] = 8'd0;  // revision
      return w;
   endfunction
endpackage

// File: rtl/cr_ctl_status.sv
module cr_ctl_status
   import cr_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_req,
   input  logic        wr_loc,
   input  logic [31:0] wdata,
   input  logic        done,
   input  logic        err,
   output loc_t        loc_q,
   output ctl_t        ctl_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         loc_q <= '0;
         ctl_q <= '0;
      end else begin
         if (wr_req) begin
            case (wdata)
               CODE_READY: ctl_q.idle <= 1'b0;
               CODE_IDLE:  ctl_q.idle <= 1'b1;
               default:    ;
            endcase
         end
         if (done && err) ctl_q.fatal <= 1'b1;
         if (wr_loc && wdata == CODE_LOC_REQ) begin
            loc_q.granted   <= 1'b1;
            loc_q.seized    <= 1'b0;
            loc_q.assigned  <= 1'b1;
            loc_q.reg_valid <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/cr_start_ctl.sv
module cr_start_ctl
   import cr_pkg::*;
#(
   parameter int unsigned LEN_W   = 16,
   parameter int unsigned EFF_MAX = 3968
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_start,
   input  logic             wr_cancel,
   input  logic [31:0]      wdata,
   input  logic [31:0]      hdr_size,
   input  logic             done,
   output logic             busy,
   output logic             req_valid,
   output logic [LEN_W-1:0] req_len,
   output logic             cancel
);
   localparam logic [31:0] MAX32 = 32'(EFF_MAX);

   logic             start_go;
   logic             cancel_go;
   logic [LEN_W-1:0] len_calc;

   assign start_go  = wr_start  && (wdata == CODE_GO) && !busy;
   assign cancel_go = wr_cancel && (wdata == CODE_GO) && busy;
   assign len_calc  = (hdr_size < MAX32) ? hdr_size[LEN_W-1:0] : MAX32[LEN_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         req_valid <= 1'b0;
         req_len   <= '0;
         cancel    <= 1'b0;
      end else begin
         req_valid <= start_go;
         cancel    <= cancel_go;
         if (start_go) begin
            busy    <= 1'b1;
            req_len <= len_calc;
         end else if (done) begin
            busy    <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/cr_rd_mux.sv
module cr_rd_mux
   import cr_pkg::*;
#(
   parameter int unsigned ADDR_W    = 12,
   parameter bit          RD_PIPE   = 1'b0,
   parameter logic [31:0] DBUF_BASE = 32'hFED4_0080,
   parameter int unsigned DBUF_SIZE = 3968,
   parameter logic [15:0] VENDOR_ID = 16'h1AB5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  loc_t              loc_q,
   input  ctl_t              ctl_q,
   input  logic              busy,
   output logic [31:0]       rdata
);
   localparam logic [31:0] ID_WORD  = intf_id_word();
   localparam logic [31:0] SIZE_W   = 32'(DBUF_SIZE);

   logic [ADDR_W-1:0] waddr;
   logic [31:0]       word;
   logic [31:0]       shifted;

   assign waddr = {addr[ADDR_W-1:2], 2'b00};

   always_comb begin
      word = '0;
      case (waddr)
         ADDR_W'(OFS_LOC_STATE):  word = {30'd0, loc_q.assigned, loc_q.reg_valid};
         ADDR_W'(OFS_LOC_STS):    word = {30'd0, loc_q.seized, loc_q.granted};
         ADDR_W'(OFS_INTF_ID):    word = ID_WORD;
         ADDR_W'(OFS_INTF_ID2):   word = {16'd0, VENDOR_ID};
         ADDR_W'(OFS_CTRL_STS):   word = {30'd0, ctl_q.idle, ctl_q.fatal};
         ADDR_W'(OFS_CTRL_START): word = {31'd0, busy};
         ADDR_W'(OFS_CMD_SIZE):   word = SIZE_W;
         ADDR_W'(OFS_CMD_ADDR):   word = DBUF_BASE;
         ADDR_W'(OFS_RSP_SIZE):   word = SIZE_W;
         ADDR_W'(OFS_RSP_ADDR):   word = DBUF_BASE;
         default:                 word = '0;
      endcase
   end

   assign shifted = word >> {addr[1:0], 3'b000};

   generate
      if (RD_PIPE) begin : g_pipe
         always_ff @(posedge clk) begin
            if (!rst_n) rdata <= '0;
            else        rdata <= shifted;
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign rdata = shifted;
      end
   endgenerate
endmodule

// File: rtl/cmdrsp_regs.sv
module cmdrsp_regs
   import cr_pkg::*;
#(
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned LEN_W       = 16,
   parameter int unsigned DBUF_SIZE   = 3968,
   parameter int unsigned BE_BUF_SIZE = 4096,
   parameter logic [31:0] DBUF_BASE   = 32'hFED4_0080,
   parameter logic [15:0] VENDOR_ID   = 16'h1AB5,
   parameter bit          RD_PIPE     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr_en,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [31:0]       hdr_cmd_size,
   output logic              be_req_valid,
   output logic [LEN_W-1:0]  be_req_len,
   output logic              be_cancel,
   input  logic              be_done,
   input  logic              be_err
);
   localparam int unsigned EFF_MAX = (BE_BUF_SIZE < DBUF_SIZE) ? BE_BUF_SIZE : DBUF_SIZE;

   generate
      if (ADDR_W < 7) begin : g_bad_addr
         $error("ADDR_W too small for the register map");
      end
      if (LEN_W > 32 || (64'(EFF_MAX) >> LEN_W) != 0) begin : g_bad_len
         $error("LEN_W cannot hold the buffer size");
      end
      if (EFF_MAX == 0) begin : g_bad_size
         $error("buffer size must be nonzero");
      end
   endgenerate

   logic wr_req, wr_loc, wr_start, wr_cancel;
   logic busy_q;
   loc_t loc_q;
   ctl_t ctl_q;

   assign wr_req    = bus_wr_en && bus_addr == ADDR_W'(OFS_CTRL_REQ);
   assign wr_loc    = bus_wr_en && bus_addr == ADDR_W'(OFS_LOC_CTRL);
   assign wr_start  = bus_wr_en && bus_addr == ADDR_W'(OFS_CTRL_START);
   assign wr_cancel = bus_wr_en && bus_addr == ADDR_W'(OFS_CTRL_CANCEL);

   cr_ctl_status u_sts (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_req(wr_req),
      .wr_loc(wr_loc),
      .wdata (bus_wdata),
      .done  (be_done),
      .err   (be_err),
      .loc_q (loc_q),
      .ctl_q (ctl_q)
   );

   cr_start_ctl #(.LEN_W(LEN_W), .EFF_MAX(EFF_MAX)) u_start (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_start (wr_start),
      .wr_cancel(wr_cancel),
      .wdata    (bus_wdata),
      .hdr_size (hdr_cmd_size),
      .done     (be_done),
      .busy     (busy_q),
      .req_valid(be_req_valid),
      .req_len  (be_req_len),
      .cancel   (be_cancel)
   );

   cr_rd_mux #(
      .ADDR_W   (ADDR_W),
      .RD_PIPE  (RD_PIPE),
      .DBUF_BASE(DBUF_BASE),
      .DBUF_SIZE(DBUF_SIZE),
      .VENDOR_ID(VENDOR_ID)
   ) u_rd (
      .clk  (clk),
      .rst_n(rst_n),
      .addr (bus_addr),
      .loc_q(loc_q),
      .ctl_q(ctl_q),
      .busy (busy_q),
      .rdata(bus_rdata)
   );
endmodule

// File: rtl/cr_regs_chk.sv
module cr_regs_chk
   import cr_pkg::*;
#(
   parameter int unsigned ADDR_W  = 12,
   parameter int unsigned LEN_W   = 16,
   parameter int unsigned EFF_MAX = 3968
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr_en,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic              be_req_valid,
   input logic [LEN_W-1:0]  be_req_len,
   input logic              be_cancel,
   input logic              be_done,
   input logic              busy,
   input logic              fatal,
   input logic              granted,
   input logic              assigned
);
   AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      be_req_valid |=> !be_req_valid); // R3
   AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      be_req_valid |-> ($past(bus_wr_en) && $past(bus_addr) == ADDR_W'(OFS_CTRL_START)
                        && $past(bus_wdata) == CODE_GO && !$past(busy) && busy)); // R2
   AST_CANCEL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      be_cancel |-> $past(busy)); // R4
   AST_LEN_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      be_req_valid |-> (32'(be_req_len) <= 32'(EFF_MAX))); // R9
   AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (be_done && busy) |=> !busy); // R5
   AST_FATAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      fatal |=> fatal); // R5
   AST_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_en && bus_addr == ADDR_W'(OFS_LOC_CTRL) && bus_wdata == CODE_LOC_REQ)
      |=> (granted && assigned)); // R6
endmodule

bind cmdrsp_regs cr_regs_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .EFF_MAX(EFF_MAX)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_wr_en   (bus_wr_en),
   .bus_addr    (bus_addr),
   .bus_wdata   (bus_wdata),
   .be_req_valid(be_req_valid),
   .be_req_len  (be_req_len),
   .be_cancel   (be_cancel),
   .be_done     (be_done),
   .busy        (busy_q),
   .fatal       (ctl_q.fatal),
   .granted     (loc_q.granted),
   .assigned    (loc_q.assigned)
);

// File: tb/cmdrsp_regs_tb.sv
module cmdrsp_regs_tb;
   localparam int AW  = 12;
   localparam int LW  = 16;
   localparam int LAT = 6;
   localparam logic [31:0] BASE = 32'hFED4_0080;
   localparam int SIZE = 3968;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr_en = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [31:0]   hdr_cmd_size = '0;
   logic          be_req_valid;
   logic [LW-1:0] be_req_len;
   logic          be_cancel;
   logic          be_done = 1'b0;
   logic          be_err = 1'b0;

   int errs = 0;
   int checks = 0;
   bit fin = 1'b0;

   always #2.5 clk = ~clk;

   cmdrsp_regs u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hdr_cmd_size(hdr_cmd_size),
      .be_req_valid(be_req_valid), .be_req_len(be_req_len), .be_cancel(be_cancel),
      .be_done(be_done), .be_err(be_err)
   );

   // behavioural reference model
   bit m_idle, m_fatal, m_start, m_gr, m_sz, m_as, m_vl, m_req, m_can;
   int m_len;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_idle = 0; m_fatal = 0; m_start = 0; m_gr = 0; m_sz = 0;
         m_as = 0; m_vl = 0; m_req = 0; m_can = 0; m_len = 0;
      end else begin
         m_req = 0;
         m_can = 0;
         if (bus_wr_en) begin
            if (bus_addr == 'h40 && bus_wdata == 1) m_idle = 0;
            if (bus_addr == 'h40 && bus_wdata == 2) m_idle = 1;
            if (bus_addr == 'h08 && bus_wdata == 1) begin
               m_gr = 1; m_sz = 0; m_as = 1; m_vl = 1;
            end
            if (bus_addr == 'h48 && bus_wdata == 1 && m_start) m_can = 1;
            if (bus_addr == 'h4C && bus_wdata == 1 && !m_start) begin
               m_start = 1;
               m_req = 1;
               m_len = (hdr_cmd_size < SIZE) ? int'(hdr_cmd_size) : SIZE;
            end
         end
         if (be_done) begin
            m_start = 0;
            if (be_err) m_fatal = 1;
         end
      end
   end

   function automatic logic [31:0] m_read(input logic [AW-1:0] a);
      logic [31:0] w;
      case (int'({a[AW-1:2], 2'b00}))
         'h00: w = {30'd0, m_as, m_vl};
         'h0C: w = {30'd0, m_sz, m_gr};
         'h30: w = 32'h0002_5811;
         'h34: w = 32'h0000_1AB5;
         'h44: w = {30'd0, m_idle, m_fatal};
         'h4C: w = {31'd0, m_start};
         'h58, 'h64: w = SIZE;
         'h5C, 'h68: w = BASE;
         default: w = 0;
      endcase
      return w >> (8 * a[1:0]);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !fin) begin
         chk("R11 per-cycle rdata", bus_rdata, m_read(bus_addr));
         chk("R3 per-cycle req_valid", 32'(be_req_valid), 32'(m_req));
         if (m_req) chk("R9 per-cycle req_len", 32'(be_req_len), m_len);
         chk("R4 per-cycle cancel", 32'(be_cancel), 32'(m_can));
      end
   end

   task automatic wr(input int a, input int d);
      @(posedge clk); #1;
      bus_wr_en = 1'b1; bus_addr = AW'(a); bus_wdata = d;
      @(posedge clk); #1;
      bus_wr_en = 1'b0;
   endtask

   task automatic rd(input int a, input logic [31:0] exp, input string tag);
      @(posedge clk); #1;
      bus_addr = AW'(a);
      @(negedge clk);
      chk(tag, bus_rdata, exp);
   endtask

   task automatic finish_cmd(input bit e);
      repeat (LAT) @(posedge clk);
      #1; be_done = 1'b1; be_err = e;
      @(posedge clk); #1;
      be_done = 1'b0; be_err = 1'b0;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errs, checks);
   endtask

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      // reset values
      rd('h44, 0, "R1 reset control status");
      rd('h00, 0, "R6 reset locality state");
      rd('h0C, 0, "R6 reset locality status");
      rd('h4C, 0, "R2 reset start bit");
      rd('h30, 32'h0002_5811, "R8 interface id");
      rd('h34, 32'h0000_1AB5, "R8 vendor id");
      rd('h58, SIZE, "R10 cmd size");
      rd('h64, SIZE, "R10 rsp size");
      rd('h5C, BASE, "R10 cmd addr");
      rd('h68, BASE, "R10 rsp addr");
      // byte-offset reads
      rd('h31, 32'h0000_0258, "R11 byte offset 1");
      rd('h32, 32'h0000_0002, "R11 byte offset 2");
      rd('h5F, 32'h0000_00FE, "R11 byte offset 3");
      rd('h7C, 0, "R12 unmapped read");
      // control request
      wr('h40, 2); rd('h44, 2, "R1 go idle");
      wr('h40, 3); rd('h44, 2, "R1 other code ignored");
      wr('h40, 1); rd('h44, 0, "R1 ready clears idle");
      // locality
      wr('h08, 2); rd('h0C, 0, "R7 relinquish no effect");
      wr('h08, 8); rd('h00, 0, "R7 reset establishment no effect");
      wr('h08, 4); rd('h0C, 0, "R7 other code no effect");
      wr('h08, 1);
      rd('h0C, 1, "R6 granted set seized clear");
      rd('h00, 3, "R6 assigned and valid");
      // read-only writes
      wr('h30, 0); rd('h30, 32'h0002_5811, "R12 id write ignored");
      wr('h58, 5); rd('h58, SIZE, "R12 size write ignored");
      wr('h0C, 0); rd('h0C, 1, "R12 status write ignored");
      // cancel while idle
      wr('h48, 1); rd('h4C, 0, "R4 cancel while idle ignored");
      // start with short header
      wr('h4C, 2); rd('h4C, 0, "R2 non-one start ignored");
      hdr_cmd_size = 100;
      wr('h4C, 1); rd('h4C, 1, "R2 start bit set");
      hdr_cmd_size = 50;
      wr('h4C, 1); rd('h4C, 1, "R2 retrigger ignored");
      wr('h48, 1);
      finish_cmd(1'b0);
      rd('h4C, 0, "R5 done clears start");
      rd('h44, 0, "R5 no fatal on success");
      // start with oversize header, error completion
      hdr_cmd_size = 5000;
      wr('h4C, 1);
      finish_cmd(1'b1);
      rd('h44, 1, "R5 fatal on error");
      hdr_cmd_size = SIZE;
      wr('h4C, 1);
      finish_cmd(1'b0);
      rd('h44, 1, "R5 fatal stays set");
      repeat (3) @(posedge clk);
      fin = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!fin) begin
         fin = 1'b1;
         checks++;
         errs++;
         $display("FAIL watchdog expired actual=running expected=done");
         summary();
         $finish;
      end
   end
endmodule